// File: doc/BRIEF.md
# Repeating Calendar Alarm Matcher

This block keeps a four-byte alarm setting (second, minute, hour and day of month, each in BCD) and compares it with a BCD time and date that an external timekeeping counter supplies on input buses. It checks for a match once per seconds strobe. When the alarm condition holds on a strobe, it raises a one-cycle interrupt pulse.

Bit 7 of every alarm byte is a "don't care" flag for that field. The combination of the four flags sets the repeat rate: monthly, daily, hourly, once a minute or every second. Software writes and reads the alarm bytes through a byte-wide register port. Each field has a legal range. A write whose value falls outside that range is dropped without any indication.

Top module: `alarm_match_top`

## Requirements
- R1: Field select 0 is alarm seconds and field select 1 is alarm minutes. For these fields the low 7 bits of the written byte are decoded as tens*10+units, where the tens digit is bits 6:4 and the units digit is bits 3:0. The write is stored only if the decoded value is 59 or less. Otherwise the stored byte does not change.
- R2: Field select 2 is alarm hours. The low 6 bits are decoded the same way, and the write is stored only if the decoded value is 23 or less.
- R3: Field select 3 is alarm date. The low 5 bits are decoded the same way, and a write that decodes to zero is discarded.
- R4: An accepted write stores the whole byte, including bit 7 and any unused bits. reg_rdata always shows the stored byte of the field selected by reg_addr. Reset values are 0x00 for seconds, minutes and hours and 0x01 for date.
- R5: With bit 7 clear in all four fields (monthly), a strobe fires only when date, hour, minute and second all match.
- R6: With bit 7 set only in the date field (daily), a strobe fires when hour, minute and second match. The date is ignored.
- R7: With bit 7 set in the date and hour fields only (hourly), a strobe fires when minute and second match.
- R8: With bit 7 set in the date, hour and minute fields only (per minute), a strobe fires when the second matches.
- R9: With bit 7 set in all four fields, or with any other flag combination, every strobe fires.
- R10: irq goes high for exactly one cycle, in the cycle after a strobe cycle that fires. irq never rises without a strobe. The comparison uses the alarm bytes held before a write in the same cycle.
- R11: The comparison looks only at the field bits: low 7 bits for seconds and minutes, low 6 for hours and low 5 for date, on both the alarm and the time inputs. Bits outside those fields have no effect on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the alarm register port |
| reg_addr | input | 2 | Field select: 0 second, 1 minute, 2 hour, 3 date |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Stored byte of the selected field |
| tick | input | 1 | Seconds strobe from the timekeeping counter |
| now_sec | input | 8 | Current BCD second |
| now_min | input | 8 | Current BCD minute |
| now_hour | input | 8 | Current BCD hour |
| now_date | input | 8 | Current BCD day of month |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A bad range check or a corrupted alarm byte appears on reg_rdata as soon as the field is selected, in the cycle after the write. A wrong flag decode or a wrong field compare appears on irq one cycle after the strobe: a pulse is missing or extra, depending on how the flags and the time inputs combine. A pulse that lasts more than one cycle, or one that arrives without a strobe, shows up directly on irq.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int FLAG_BIT   = BYTE_W - 1;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH, RPT_DAY, RPT_HOUR, RPT_MINUTE, RPT_SECOND
  } rpt_e;

  // Two BCD digits into binary.
  function automatic logic [BYTE_W-1:0] bcd_value(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] tens;
    logic [BYTE_W-1:0] ones;
    tens = {4'b0, b[7:4]};
    ones = {4'b0, b[3:0]};
    return tens * 8'd10 + ones;
  endfunction

  // Bits that carry the value of each field.
  function automatic logic [BYTE_W-1:0] field_bits(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'h3F;
      default:      return 8'h1F;
    endcase
  endfunction

  function automatic int field_lo(input int idx);
    return (idx == F_DATE) ? 1 : 0;
  endfunction

  function automatic int field_hi(input int idx);
    case (idx)
      F_SEC, F_MIN: return 59;
      F_HOUR:       return 23;
      default:      return 255;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_rst(input int idx);
    return (idx == F_DATE) ? 8'h01 : 8'h00;
  endfunction

  // Flag pattern {date, hour, minute, second} to repeat rate.
  function automatic rpt_e decode_rpt(input logic [NUM_FIELDS-1:0] m);
    case (m)
      4'b0000: return RPT_MONTH;
      4'b1000: return RPT_DAY;
      4'b1100: return RPT_HOUR;
      4'b1110: return RPT_MINUTE;
      default: return RPT_SECOND;
    endcase
  endfunction

  // Fields taking part in the comparison, bit i for field i.
  function automatic logic [NUM_FIELDS-1:0] compare_set(input rpt_e r);
    case (r)
      RPT_MONTH:  return 4'b1111;
      RPT_DAY:    return 4'b0111;
      RPT_HOUR:   return 4'b0011;
      RPT_MINUTE: return 4'b0001;
      default:    return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BITS = 8'h7F,
  parameter int                LO   = 0,
  parameter int                HI   = 59,
  parameter logic [BYTE_W-1:0] RST  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              accept,
  output logic [BYTE_W-1:0] value
);
  logic [BYTE_W-1:0] decoded;
  logic              in_range;

  assign decoded  = bcd_value(wdata & BITS);
  assign in_range = (int'(decoded) >= LO) && (int'(decoded) <= HI);
  assign accept   = wr_sel && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= RST;
    else if (accept) value <= wdata;
  end
endmodule

// File: rtl/alarm_mode_decode.sv
module alarm_mode_decode
  import alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] flags,
  output rpt_e                  mode,
  output logic [NUM_FIELDS-1:0] cmp_en
);
  assign mode   = decode_rpt(flags);
  assign cmp_en = compare_set(mode);
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_pkg::*;
(
  input  logic [NUM_FIELDS*BYTE_W-1:0] alarm_flat,
  input  logic [NUM_FIELDS*BYTE_W-1:0] now_flat,
  input  logic [NUM_FIELDS-1:0]        cmp_en,
  output logic                         hit
);
  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_eq
    localparam logic [BYTE_W-1:0] B = field_bits(i);
    assign field_eq[i] = ((alarm_flat[i*BYTE_W +: BYTE_W] & B) ==
                          (now_flat[i*BYTE_W +: BYTE_W] & B));
  end

  assign hit = &(field_eq | ~cmp_en);
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic [BYTE_W-1:0] now_sec,
  input  logic [BYTE_W-1:0] now_min,
  input  logic [BYTE_W-1:0] now_hour,
  input  logic [BYTE_W-1:0] now_date,
  output logic              irq
);
  localparam int FLAT_W = NUM_FIELDS * BYTE_W;

  logic [NUM_FIELDS-1:0] wr_sel;
  logic [NUM_FIELDS-1:0] acc;
  logic [NUM_FIELDS-1:0] mask_bits;
  logic [NUM_FIELDS-1:0] cmp_en;
  logic [FLAT_W-1:0]     alarm_flat;
  logic [FLAT_W-1:0]     now_flat;
  logic [BYTE_W-1:0]     alarm_arr [NUM_FIELDS];
  logic                  wr_accept;
  logic                  match_hit;
  rpt_e                  rpt_mode;

  assign now_flat = {now_date, now_hour, now_min, now_sec};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign wr_sel[i] = reg_wr && (reg_addr == SEL_W'(i));
    alarm_field_reg #(
      .BITS(field_bits(i)),
      .LO  (field_lo(i)),
      .HI  (field_hi(i)),
      .RST (field_rst(i))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_sel(wr_sel[i]),
      .wdata (reg_wdata),
      .accept(acc[i]),
      .value (alarm_flat[i*BYTE_W +: BYTE_W])
    );
    assign alarm_arr[i] = alarm_flat[i*BYTE_W +: BYTE_W];
    assign mask_bits[i] = alarm_flat[i*BYTE_W + FLAG_BIT];
  end

  assign wr_accept = |acc;
  assign reg_rdata = alarm_arr[reg_addr];

  alarm_mode_decode u_mode (
    .flags (mask_bits),
    .mode  (rpt_mode),
    .cmp_en(cmp_en)
  );

  alarm_compare u_cmp (
    .alarm_flat(alarm_flat),
    .now_flat  (now_flat),
    .cmp_en    (cmp_en),
    .hit       (match_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && match_hit;
  end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
  import alarm_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_wr,
  input logic [SEL_W-1:0]             reg_addr,
  input logic [BYTE_W-1:0]            reg_wdata,
  input logic                         tick,
  input logic                         irq,
  input logic [NUM_FIELDS*BYTE_W-1:0] alarm_flat,
  input logic                         wr_accept,
  input logic                         match_hit,
  input rpt_e                         rpt_mode
);
  logic              pend;
  logic [SEL_W-1:0]  pend_addr;
  logic [BYTE_W-1:0] pend_data;
  logic [BYTE_W-1:0] stored_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend      <= reg_wr && wr_accept;
      pend_addr <= reg_addr;
      pend_data <= reg_wdata;
    end
  end

  assign stored_now = alarm_flat[pend_addr*BYTE_W +: BYTE_W];

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick)); // R10
  AST_IRQ_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(match_hit)); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !tick) |=> !irq); // R10
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_accept) |=> (alarm_flat == $past(alarm_flat))); // R1
  AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (stored_now == pend_data)); // R4
  AST_FREE_RUN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt_mode == RPT_SECOND) |=> irq); // R9
endmodule

bind alarm_match_top alarm_match_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tick      (tick),
  .irq       (irq),
  .alarm_flat(alarm_flat),
  .wr_accept (wr_accept),
  .match_hit (match_hit),
  .rpt_mode  (rpt_mode)
);

// File: tb/alarm_match_top_tb_top.sv
`timescale 1ns/1ps
module alarm_match_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h00;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R4";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  alarm_match_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .irq(irq)
  );

  // Reference model
  logic [7:0] shadow [4];
  logic       exp_irq;

  function automatic int digits(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic bit ref_ok(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0, 2'd1: return digits(d & 8'h7F) < 60;
      2'd2:       return digits(d & 8'h3F) < 24;
      default:    return digits(d & 8'h1F) != 0;
    endcase
  endfunction

  function automatic bit ref_fire(input logic [7:0] s, m, h, d,
                                  input logic [7:0] ns, nm, nh, nd);
    bit es, em, eh, ed;
    es = (s[6:0] == ns[6:0]);
    em = (m[6:0] == nm[6:0]);
    eh = (h[5:0] == nh[5:0]);
    ed = (d[4:0] == nd[4:0]);
    if (!d[7] && !h[7] && !m[7] && !s[7]) return ed && eh && em && es;
    if ( d[7] && !h[7] && !m[7] && !s[7]) return eh && em && es;
    if ( d[7] &&  h[7] && !m[7] && !s[7]) return em && es;
    if ( d[7] &&  h[7] &&  m[7] && !s[7]) return es;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      shadow[0] = 8'h00; shadow[1] = 8'h00; shadow[2] = 8'h00; shadow[3] = 8'h01;
      exp_irq = 1'b0;
    end else begin
      exp_irq = tick && ref_fire(shadow[0], shadow[1], shadow[2], shadow[3],
                                 now_sec, now_min, now_hour, now_date);
      if (reg_wr && ref_ok(reg_addr, reg_wdata)) shadow[reg_addr] = reg_wdata;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({cur_req, " model irq"}, {7'd0, irq}, {7'd0, exp_irq});
      chk({cur_req, " model rdata"}, reg_rdata, shadow[reg_addr]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic strobe(input logic [7:0] s, m, h, d, input bit do_tick,
                        input bit exp, input string req);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d; tick = do_tick;
    @(negedge clk);
    tick = 1'b0;
    chk(req, {7'd0, irq}, {7'd0, exp});
    @(negedge clk);
    chk("R10 pulse ends", {7'd0, irq}, 8'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset values
    cur_req = "R4";
    rd(2'd0, 8'h00, "R4 reset sec");
    rd(2'd1, 8'h00, "R4 reset min");
    rd(2'd2, 8'h00, "R4 reset hour");
    rd(2'd3, 8'h01, "R4 reset date");
    chk("R10 reset irq", {7'd0, irq}, 8'd0);

    cur_req = "R1";
    wr(2'd0, 8'h59, 8'h59, "R1 sec 59 accepted");
    wr(2'd0, 8'h60, 8'h59, "R1 sec 60 discarded");
    wr(2'd0, 8'hB0, 8'hB0, "R4 sec flag byte stored whole");
    wr(2'd1, 8'h7A, 8'h00, "R1 min decodes 80 discarded");
    wr(2'd1, 8'h45, 8'h45, "R1 min 45 accepted");

    cur_req = "R2";
    wr(2'd2, 8'h23, 8'h23, "R2 hour 23 accepted");
    wr(2'd2, 8'h24, 8'h23, "R2 hour 24 discarded");
    wr(2'd2, 8'h52, 8'h52, "R2 hour bit6 ignored in range, stored");

    cur_req = "R3";
    wr(2'd3, 8'h00, 8'h01, "R3 date zero discarded");
    wr(2'd3, 8'h80, 8'h01, "R3 date flag-only zero discarded");
    wr(2'd3, 8'h15, 8'h15, "R3 date 15 accepted");

    cur_req = "R5";
    wr(2'd0, 8'h10, 8'h10, "R5 setup sec");
    wr(2'd1, 8'h20, 8'h20, "R5 setup min");
    wr(2'd2, 8'h05, 8'h05, "R5 setup hour");
    wr(2'd3, 8'h07, 8'h07, "R5 setup date");
    strobe(8'h10, 8'h20, 8'h05, 8'h07, 1'b1, 1'b1, "R5 monthly full match fires");
    strobe(8'h10, 8'h20, 8'h05, 8'h08, 1'b1, 1'b0, "R5 monthly date differs");
    strobe(8'h11, 8'h20, 8'h05, 8'h07, 1'b1, 1'b0, "R5 monthly second differs");
    cur_req = "R10";
    strobe(8'h10, 8'h20, 8'h05, 8'h07, 1'b0, 1'b0, "R10 match without strobe");
    cur_req = "R11";
    strobe(8'h90, 8'hA0, 8'hC5, 8'hE7, 1'b1, 1'b1, "R11 outside bits ignored");

    cur_req = "R6";
    wr(2'd3, 8'h87, 8'h87, "R6 date flag set");
    strobe(8'h10, 8'h20, 8'h05, 8'h12, 1'b1, 1'b1, "R6 daily other date fires");
    strobe(8'h10, 8'h21, 8'h05, 8'h12, 1'b1, 1'b0, "R6 daily minute differs");

    cur_req = "R7";
    wr(2'd2, 8'h85, 8'h85, "R7 hour flag set");
    strobe(8'h10, 8'h20, 8'h09, 8'h12, 1'b1, 1'b1, "R7 hourly other hour fires");
    strobe(8'h10, 8'h21, 8'h09, 8'h12, 1'b1, 1'b0, "R7 hourly minute differs");

    cur_req = "R8";
    wr(2'd1, 8'hA0, 8'hA0, "R8 minute flag set");
    strobe(8'h10, 8'h33, 8'h09, 8'h12, 1'b1, 1'b1, "R8 per-minute fires");
    strobe(8'h11, 8'h33, 8'h09, 8'h12, 1'b1, 1'b0, "R8 per-minute second differs");

    cur_req = "R9";
    wr(2'd0, 8'h90, 8'h90, "R9 second flag set");
    strobe(8'h44, 8'h33, 8'h11, 8'h02, 1'b1, 1'b1, "R9 all flags fires");
    wr(2'd3, 8'h07, 8'h07, "R9 date flag cleared");
    strobe(8'h44, 8'h33, 8'h11, 8'h02, 1'b1, 1'b1, "R9 odd combo 0111 fires");
    wr(2'd1, 8'h20, 8'h20, "R9 minute flag cleared");
    wr(2'd2, 8'h05, 8'h05, "R9 hour flag cleared");
    strobe(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, 1'b1, "R9 only second flag fires");

    cur_req = "R10";
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule